// File: doc/BRIEF.md
# Outbound Request Queue with Attention Line

This block holds outbound command messages until an external bus engine carries them to a controller. Each payload arrives as a byte stream. The block frames it with a leading length byte and parks it in one of a fixed number of storage slots. Messages leave in arrival order.

While at least one message is waiting, an active-low attention output asks the controller to come and read. The bus engine pulls the head frame out byte by byte over a second stream. It then reports the end of the transfer with a done strobe. The head is freed only when that strobe arrives after every byte of the frame has been taken. An early strobe, or an explicit rewind, restarts the head frame at its length byte.

A millisecond tick input drives a retry timer. If the head stays unconfirmed for `TIMEOUT_MS` ticks, the attention line is released for one tick and the frame restarts from byte 0. The line is then driven low again.

Both streams use valid/ready. A byte moves on a clock edge where valid and ready are both high. A producer keeps its data stable while valid is high and ready is low. On the input side the block never applies back-pressure to reject a message. When no slot is free, it consumes the whole message, discards it and flags an error. `in_ready` is low only during reset.

Top module: `oq_req_queue`

## Requirements
- R1: During reset and on the first cycle after it, `attn_n` is 1, `out_valid` is 0 and `enq_err` is 0. `in_ready` is 1 from the second cycle after reset is released.
- R2: A stored frame is a length byte equal to the payload byte count, followed by the payload bytes in arrival order. The frame size is therefore payload + 1. `out_last` is 1 exactly on the final frame byte.
- R3: Frames are presented at the output in the order their messages completed on the input.
- R4: A message claims the lowest-numbered free slot on its first beat. If all `SLOTS` slots are held, `enq_err` pulses for one cycle, one cycle after the first beat. The message's bytes are still consumed, but the message is never queued.
- R5: `attn_n` is 0 from the cycle after a message is committed until the queue is empty, except during a timeout release. It is 1 while the queue is empty.
- R6: A `xfer_done` pulse after all bytes of the head frame have been transferred removes the head and frees its slot. The next frame is then presented from its length byte.
- R7: A `xfer_done` pulse before the head frame is fully transferred keeps the head queued and sets its read position back to the length byte.
- R8: A `rewind` pulse sets the head read position back to the length byte without removing the head.
- R9: After `TIMEOUT_MS` ticks without a completion, `attn_n` goes to 1, `out_valid` goes to 0 and the read position returns to 0. On the next tick, `attn_n` returns to 0 and the frame is offered again from its length byte.
- R10: Payload bytes beyond `SLOT_BYTES`-1 are discarded. The length byte is then `SLOT_BYTES`-1 (33 by default).
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold steady on the next cycle, unless a done, rewind or tick arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Final payload byte of a message |
| enq_err | output | 1 | One-cycle pulse: message refused, pool full |
| out_valid | output | 1 | Head frame byte available |
| out_ready | input | 1 | Bus engine takes the byte |
| out_data | output | 8 | Head frame byte at the read position |
| out_last | output | 1 | Byte is the last of the frame |
| xfer_done | input | 1 | Bus engine reports end of transfer |
| rewind | input | 1 | Restart the head frame at byte 0 |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| attn_n | output | 1 | Active-low request for the controller to read |

## Verification
The hardest situation to reach from the ports is a timeout release in the middle of a frame. It needs a head that has been partly read and then left unconfirmed for a whole timeout window, without any done pulse clearing the timer. The bench shrinks `TIMEOUT_MS` to 4 and reads two bytes of a frame. It then issues ticks one at a time and checks the release edge, the re-assert edge and the restart at the length byte.

Pool exhaustion is reached by filling every slot before draining anything. The bench then sends one more message and confirms that it never appears at the output.

// File: rtl/oq_pkg.sv
package oq_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [1:0] {W_IDLE, W_FILL, W_DROP} wr_state_e;
endpackage

// File: rtl/oq_slot_alloc.sv
module oq_slot_alloc #(
  parameter int SLOTS = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          claim_en,
  input  logic          free_en,
  input  logic [SW-1:0] free_idx,
  output logic          avail,
  output logic [SW-1:0] grant_idx
);
  logic [SLOTS-1:0] used_q;

  // lowest-numbered free slot wins
  always_comb begin
    avail = 1'b0;
    grant_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        avail = 1'b1;
        grant_idx = SW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
    end else begin
      if (claim_en) used_q[grant_idx] <= 1'b1;
      if (free_en)  used_q[free_idx]  <= 1'b0;
    end
  end

  // R4
  claim_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_en |=> used_q[$past(grant_idx)]);
  // R6
  free_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> used_q[free_idx]);
endmodule

// File: rtl/oq_order_ring.sv
module oq_order_ring #(
  parameter int SLOTS = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [SW-1:0] push_idx,
  input  logic          pop,
  output logic [SW-1:0] head_idx,
  output logic          nonempty
);
  logic [SW-1:0] ord_q [SLOTS];
  logic [SW-1:0] rd_q, wr_q;
  logic [SW:0]   cnt_q;

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] p);
    return (p == SW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_idx = ord_q[rd_q];
  assign nonempty = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (push) ord_q[wr_q] <= push_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= nxt(wr_q);
      if (pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + (SW+1)'(push) - (SW+1)'(pop);
    end
  end

  // R3
  ring_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != (SW+1)'(SLOTS)) || pop);
  // R6
  ring_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
endmodule

// File: rtl/oq_retry_timer.sv
module oq_retry_timer #(
  parameter int TIMEOUT_MS = 5000,
  localparam int TW = $clog2(TIMEOUT_MS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic clear,
  input  logic tick,
  output logic released,
  output logic expire
);
  logic [TW-1:0] cnt_q;
  logic          rel_q;

  assign released = rel_q;
  assign expire   = active && !clear && tick && !rel_q
                    && (cnt_q == TW'(TIMEOUT_MS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !active || clear) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (tick) begin
      if (rel_q) begin
        rel_q <= 1'b0;
      end else if (expire) begin
        rel_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9
  release_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> $past(tick) && $past(active));
  // R9
  release_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q && tick && active && !clear |=> !rel_q);
endmodule

// File: rtl/oq_req_queue.sv
module oq_req_queue
  import oq_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 34,
  parameter int TIMEOUT_MS = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       enq_err,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last,
  input  logic       xfer_done,
  input  logic       rewind,
  input  logic       ms_tick,
  output logic       attn_n
);
  localparam int SW      = $clog2(SLOTS);
  localparam int CW      = $clog2(SLOT_BYTES + 1);
  localparam int MAX_PAY = SLOT_BYTES - 1;

  byte_t         mem    [SLOTS][SLOT_BYTES];
  logic [CW-1:0] size_q [SLOTS];

  wr_state_e     wr_st_q;
  logic [SW-1:0] wr_slot_q;
  logic [CW-1:0] wr_cnt_q;
  logic          rdy_q, err_q;

  logic          avail, nonempty, released, expire;
  logic [SW-1:0] grant_idx, head_idx, wr_sel;
  logic [CW-1:0] pos_q, size_h, wr_base, cnt_n, wr_addr;
  logic          beat, claim, refuse, wr_en, commit, complete, pop, restart;

  // write side
  assign in_ready = rdy_q;
  assign enq_err  = err_q;
  assign beat     = in_valid && rdy_q;
  assign claim    = beat && (wr_st_q == W_IDLE) && avail;
  assign refuse   = beat && (wr_st_q == W_IDLE) && !avail;
  assign wr_en    = claim || (beat && wr_st_q == W_FILL);
  assign commit   = wr_en && in_last;
  assign wr_sel   = (wr_st_q == W_IDLE) ? grant_idx : wr_slot_q;
  assign wr_base  = (wr_st_q == W_IDLE) ? '0 : wr_cnt_q;
  assign cnt_n    = (wr_base < CW'(MAX_PAY)) ? wr_base + 1'b1 : wr_base;
  assign wr_addr  = wr_base + 1'b1;

  always_ff @(posedge clk) begin
    if (wr_en && wr_base < CW'(MAX_PAY)) mem[wr_sel][wr_addr] <= in_data;
    if (commit) begin
      mem[wr_sel][0] <= byte_t'(cnt_n);
      size_q[wr_sel] <= cnt_n + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_st_q   <= W_IDLE;
      wr_slot_q <= '0;
      wr_cnt_q  <= '0;
      rdy_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      err_q <= refuse;
      if (wr_en) begin
        wr_slot_q <= wr_sel;
        wr_cnt_q  <= cnt_n;
      end
      case (wr_st_q)
        W_IDLE: if (claim && !in_last) wr_st_q <= W_FILL;
                else if (refuse && !in_last) wr_st_q <= W_DROP;
        W_FILL: if (beat && in_last) wr_st_q <= W_IDLE;
        W_DROP: if (beat && in_last) wr_st_q <= W_IDLE;
        default: wr_st_q <= W_IDLE;
      endcase
    end
  end

  // read side
  assign size_h    = size_q[head_idx];
  assign complete  = nonempty && (pos_q == size_h);
  assign pop       = xfer_done && complete;
  assign restart   = expire || rewind || (xfer_done && !complete);
  assign out_valid = nonempty && !released && (pos_q < size_h);
  assign out_data  = mem[head_idx][pos_q];
  assign out_last  = (pos_q == size_h - 1'b1);
  assign attn_n    = !(nonempty && !released);

  always_ff @(posedge clk) begin
    if (!rst_n || pop || restart) pos_q <= '0;
    else if (out_valid && out_ready) pos_q <= pos_q + 1'b1;
  end

  oq_slot_alloc #(.SLOTS(SLOTS)) u_alloc (
    .clk(clk), .rst_n(rst_n), .claim_en(claim), .free_en(pop),
    .free_idx(head_idx), .avail(avail), .grant_idx(grant_idx));

  oq_order_ring #(.SLOTS(SLOTS)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(commit), .push_idx(wr_sel),
    .pop(pop), .head_idx(head_idx), .nonempty(nonempty));

  oq_retry_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(nonempty), .clear(pop),
    .tick(ms_tick), .released(released), .expire(expire));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !xfer_done && !rewind && !ms_tick
    |=> out_valid && $stable(out_data));
  // R4
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_err |-> $past(in_valid) && !$past(avail));
endmodule

// File: tb/oq_req_queue_tb.sv
module oq_req_queue_tb;
  localparam int TMO = 4;
  localparam int MAXP = 33;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, out_ready = 0, xfer_done = 0, rewind = 0, ms_tick = 0;
  logic [7:0] in_data = 0;
  logic in_ready, enq_err, out_valid, out_last, attn_n;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdat [64][40];
  int mlen [64];
  int mhead = 0, mtail = 0, rpos = 0;

  always #10 clk = ~clk;

  oq_req_queue #(.SLOTS(8), .SLOT_BYTES(34), .TIMEOUT_MS(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .enq_err(enq_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .xfer_done(xfer_done), .rewind(rewind),
    .ms_tick(ms_tick), .attn_n(attn_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int frame_byte(input int m, input int p);
    return (p == 0) ? mlen[m % 64] : int'(mdat[m % 64][p]);
  endfunction

  task automatic send_msg(input int n, input bit exp_ok);
    int m = mtail % 64;
    int k = (n > MAXP) ? MAXP : n;
    logic err_seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 1) err_seen = enq_err;
      in_valid = 1;
      in_data = 8'($urandom);
      in_last = (i == n - 1);
      if (i < MAXP) mdat[m][i + 1] = in_data;
    end
    @(negedge clk);
    if (n == 1) err_seen = enq_err;
    in_valid = 0; in_last = 0;
    chk(err_seen == !exp_ok, "R4 enq_err", err_seen, !exp_ok);
    if (exp_ok) begin
      mlen[m] = k;
      mtail++;
    end
  endtask

  task automatic read_bytes(input int k, input bit rnd);
    int got = 0;
    while (got < k) begin
      @(negedge clk);
      out_ready = rnd ? 1'($urandom % 2) : 1'b1;
      if (out_valid && out_ready) begin
        chk(out_data == 8'(frame_byte(mhead, rpos)), "R2/R3 data", out_data, frame_byte(mhead, rpos));
        chk(out_last == (rpos == mlen[mhead % 64]), "R2 last", out_last, rpos == mlen[mhead % 64]);
        rpos++; got++;
      end
    end
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); ms_tick = 1;
    @(negedge clk); ms_tick = 0;
  endtask

  task automatic drain_one(input bit rnd);
    read_bytes(mlen[mhead % 64] + 1 - rpos, rnd);
    pulse_done();
    mhead++; rpos = 0;
  endtask

  task automatic drain_all(input bit rnd);
    while (mhead != mtail) drain_one(rnd);
    chk(out_valid == 0, "R6 empty valid", out_valid, 0);
    chk(attn_n == 1, "R5 attn idle", attn_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(attn_n == 1, "R1 attn", attn_n, 1);
    chk(out_valid == 0, "R1 valid", out_valid, 0);
    chk(enq_err == 0, "R1 err", enq_err, 0);
    rst_n = 1;
    @(negedge clk);
    chk(attn_n == 1 && out_valid == 0, "R1 post", attn_n, 1);
    @(negedge clk);
    chk(in_ready == 1, "R1 ready", in_ready, 1);

    // R2/R5 basic frame
    send_msg(3, 1);
    chk(attn_n == 0, "R5 attn low", attn_n, 0);
    chk(out_valid && out_data == 8'd3, "R2 length byte", out_data, 3);

    // R11 hold under back-pressure
    held = out_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid && out_data == held, "R11 hold", out_data, held);
    end

    // R8 rewind
    read_bytes(2, 0);
    @(negedge clk); rewind = 1;
    @(negedge clk); rewind = 0;
    rpos = 0;
    chk(out_valid && out_data == 8'd3, "R8 rewind", out_data, 3);

    // R7 premature done
    read_bytes(3, 0);
    pulse_done();
    rpos = 0;
    chk(out_valid && out_data == 8'd3, "R7 premature", out_data, 3);
    drain_all(0);

    // R9 timeout
    send_msg(5, 1);
    read_bytes(2, 0);
    for (int i = 0; i < TMO - 1; i++) pulse_tick();
    chk(attn_n == 0, "R9 before", attn_n, 0);
    pulse_tick();
    chk(attn_n == 1, "R9 release", attn_n, 1);
    chk(out_valid == 0, "R9 valid off", out_valid, 0);
    pulse_tick();
    rpos = 0;
    chk(attn_n == 0, "R9 reassert", attn_n, 0);
    chk(out_valid && out_data == 8'd5, "R9 restart", out_data, 5);
    drain_all(0);

    // R10 truncation
    send_msg(40, 1);
    chk(out_data == 8'(MAXP), "R10 length", out_data, MAXP);
    drain_all(1);

    // R4/R3 pool exhaustion
    for (int i = 0; i < 8; i++) send_msg(1 + int'($urandom % 33), 1);
    send_msg(4, 0);
    send_msg(1, 0);
    drain_one(1);
    send_msg(6, 1);
    drain_all(1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      if ((mtail - mhead) < 8 && ($urandom % 2 == 1)) send_msg(1 + int'($urandom % 36), 1);
      else if (mtail != mhead) drain_one(1);
    end
    drain_all(1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule